// File: doc/BRIEF.md
# Banked Memory Mapper

This block turns each processor access in a 64 KB address space into a physical target. It sends the access to one of three storage regions: a 32 KB read/write RAM, a fixed 16 KB operating-system ROM, or one of sixteen switchable 16 KB "paged" banks. The top two address bits pick one of four 16 KB slots. Slots 0 and 1 are the two halves of RAM. Slot 2 is a window onto the currently selected paged bank. Slot 3 is the system ROM. The low fourteen bits pass through unchanged as the offset inside the slot.

Each paged bank has its own configuration bits: one that allows writes and one that marks the socket as populated. The mapper turns the write request into a gated strobe, so a write to read-only space never reaches storage. When the selected bank's socket is empty, the mapper flags slot-2 reads so the data path can return 0xFF. The bank number sits in a small register that software loads through a dedicated write port. The populated bit is captured at the moment a bank is selected.

Accesses pass through a two-state controller. `ST_IDLE` means no mapped result is presented. `ST_MAPPED` means a registered result is presented for the access sampled on the previous edge. The transitions are:
- idle-to-mapped on a request;
- mapped-to-mapped on a back-to-back request;
- mapped-to-idle when no request arrives;
- idle-to-idle while the bus is quiet.

Reset forces `ST_IDLE`.

Top module: `banked_mem_mapper`

## Requirements
- R1: While reset is held and on the first cycle after it, `map_valid` and `map_wr` are 0. The selected bank after reset is 15, and bank 15's populated bit is captured during reset.
- R2: A request sampled on edge k is presented from edge k to edge k+1 with `map_valid`=1. `map_offset` equals address bits [13:0] of that request.
- R3: Addresses with bit 15 = 0 map to region code 0 (RAM). `map_bank` equals address bit 14 (0 or 1), and `map_wr` follows `cpu_we`.
- R4: Addresses with bits [15:14] = 3 map to region code 2 (system ROM) with `map_bank` = 0, and `map_wr` is always 0.
- R5: Addresses with bits [15:14] = 2 map to region code 1 (paged). `map_bank` is the selected bank, and `map_wr` is `cpu_we` AND bit [bank] of `cfg_bank_writable`.
- R6: `bank_sel_we` loads `bank_sel_data` into the bank register. A request on the same edge still uses the previous bank, and the next request uses the new one.
- R7: `map_float` is 1 only for a slot-2 read whose selected bank was unpopulated when it was selected. Changing `cfg_bank_inserted` afterwards has no effect until the bank is selected again.
- R8: An edge with no request yields `map_valid`=0 and `map_wr`=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request this cycle |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 16 | Processor address |
| bank_sel_we | input | 1 | Load the paged-bank register |
| bank_sel_data | input | 4 | New paged-bank number |
| cfg_bank_writable | input | 16 | Per-bank write permission |
| cfg_bank_inserted | input | 16 | Per-bank populated flag |
| map_valid | output | 1 | Mapped result present |
| map_region | output | 2 | 0 RAM, 1 paged, 2 system ROM |
| map_bank | output | 4 | RAM half or paged bank number |
| map_offset | output | 14 | Offset inside the 16 KB slot |
| map_wr | output | 1 | Gated write strobe |
| map_float | output | 1 | Read must return 0xFF |

## Verification
The hardest case to reach from the ports is the stale populated flag. The flag is only a captured copy, so the stimulus must select a bank and then change that bank's `cfg_bank_inserted` bit without reselecting it. It then reads slot 2 to show the old value still governs, and finally reselects the same bank to show the new value takes hold. A second subtle case is a bank load and a slot-2 write on the same edge. The stimulus drives both together so the write is judged against the old, read-only bank 15, and then follows at once with a write that must use the newly loaded, writable bank.

// File: rtl/bmm_pkg.sv
`timescale 1ns/1ps
package bmm_pkg;

    localparam int SLOT_BITS = 2;
    localparam int NUM_SLOTS = 1 << SLOT_BITS;

    typedef enum logic [1:0] {
        RGN_RAM  = 2'd0,
        RGN_SIDE = 2'd1,
        RGN_OS   = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_MAPPED = 1'b1
    } map_state_e;

    // Fixed slot layout: two RAM halves, the paged window, then system ROM.
    function automatic region_e slot_region(input int unsigned s);
        case (s)
            0, 1:    return RGN_RAM;
            2:       return RGN_SIDE;
            default: return RGN_OS;
        endcase
    endfunction

endpackage

// File: rtl/bmm_bank_select.sv
`timescale 1ns/1ps
module bmm_bank_select #(
    parameter int BANK_W     = 4,
    parameter int RESET_BANK = 15,
    localparam int NB        = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [BANK_W-1:0] sel_data,
    input  logic [NB-1:0]     cfg_inserted,
    output logic [BANK_W-1:0] cur_bank,
    output logic              cur_inserted
);

    localparam logic [BANK_W-1:0] RST_IDX = BANK_W'(RESET_BANK);

    // Populated bit is captured at selection time, not followed afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_bank     <= RST_IDX;
            cur_inserted <= cfg_inserted[RST_IDX];
        end else if (sel_we) begin
            cur_bank     <= sel_data;
            cur_inserted <= cfg_inserted[sel_data];
        end
    end

endmodule

// File: rtl/bmm_slot_decoder.sv
`timescale 1ns/1ps
module bmm_slot_decoder
    import bmm_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BANK_W  = 4,
    localparam int OFFSET_W = ADDR_W - SLOT_BITS,
    localparam int NB       = 1 << BANK_W
) (
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_we,
    input  logic [BANK_W-1:0]   cur_bank,
    input  logic                cur_inserted,
    input  logic [NB-1:0]       cfg_writable,
    output region_e             dec_region,
    output logic [BANK_W-1:0]   dec_bank,
    output logic [OFFSET_W-1:0] dec_offset,
    output logic                dec_wr,
    output logic                dec_float
);

    localparam logic [SLOT_BITS-1:0] SIDE_SLOT = SLOT_BITS'(2);

    region_e           slot_rgn  [NUM_SLOTS];
    logic [BANK_W-1:0] slot_bank [NUM_SLOTS];
    logic              slot_wmask[NUM_SLOTS];

    logic [SLOT_BITS-1:0] slot;
    assign slot = cpu_addr[ADDR_W-1 -: SLOT_BITS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slot_rgn[s] = slot_region(s);
        if (s < 2) begin : g_ram
            assign slot_bank[s]  = BANK_W'(s);
            assign slot_wmask[s] = 1'b1;
        end else if (s == 2) begin : g_side
            assign slot_bank[s]  = cur_bank;
            assign slot_wmask[s] = cfg_writable[cur_bank];
        end else begin : g_rom
            assign slot_bank[s]  = '0;
            assign slot_wmask[s] = 1'b0;
        end
    end

    always_comb begin
        dec_region = slot_rgn[slot];
        dec_bank   = slot_bank[slot];
        dec_offset = cpu_addr[OFFSET_W-1:0];
        dec_wr     = cpu_we & slot_wmask[slot];
        dec_float  = !cpu_we && (slot == SIDE_SLOT) && !cur_inserted;
    end

endmodule

// File: rtl/banked_mem_mapper.sv
`timescale 1ns/1ps
module banked_mem_mapper
    import bmm_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BANK_W     = 4,
    parameter int RESET_BANK = 15,
    localparam int OFFSET_W  = ADDR_W - SLOT_BITS,
    localparam int NB        = 1 << BANK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                bank_sel_we,
    input  logic [BANK_W-1:0]   bank_sel_data,
    input  logic [NB-1:0]       cfg_bank_writable,
    input  logic [NB-1:0]       cfg_bank_inserted,
    output logic                map_valid,
    output logic [1:0]          map_region,
    output logic [BANK_W-1:0]   map_bank,
    output logic [OFFSET_W-1:0] map_offset,
    output logic                map_wr,
    output logic                map_float
);

    logic [BANK_W-1:0] cur_bank;
    logic              cur_inserted;

    bmm_bank_select #(
        .BANK_W     (BANK_W),
        .RESET_BANK (RESET_BANK)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_we       (bank_sel_we),
        .sel_data     (bank_sel_data),
        .cfg_inserted (cfg_bank_inserted),
        .cur_bank     (cur_bank),
        .cur_inserted (cur_inserted)
    );

    region_e             dec_region;
    logic [BANK_W-1:0]   dec_bank;
    logic [OFFSET_W-1:0] dec_offset;
    logic                dec_wr;
    logic                dec_float;

    bmm_slot_decoder #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_dec (
        .cpu_addr     (cpu_addr),
        .cpu_we       (cpu_we),
        .cur_bank     (cur_bank),
        .cur_inserted (cur_inserted),
        .cfg_writable (cfg_bank_writable),
        .dec_region   (dec_region),
        .dec_bank     (dec_bank),
        .dec_offset   (dec_offset),
        .dec_wr       (dec_wr),
        .dec_float    (dec_float)
    );

    map_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = cpu_req ? ST_MAPPED : ST_IDLE;
            ST_MAPPED: state_nx = cpu_req ? ST_MAPPED : ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    region_e             rgn_q;
    logic [BANK_W-1:0]   bank_q;
    logic [OFFSET_W-1:0] off_q;
    logic                wr_q;
    logic                flt_q;

    // Output registers: capture the decode of each sampled request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgn_q  <= RGN_NONE;
            bank_q <= '0;
            off_q  <= '0;
            wr_q   <= 1'b0;
            flt_q  <= 1'b0;
        end else if (cpu_req) begin
            rgn_q  <= dec_region;
            bank_q <= dec_bank;
            off_q  <= dec_offset;
            wr_q   <= dec_wr;
            flt_q  <= dec_float;
        end
    end

    always_comb begin
        map_valid  = (state == ST_MAPPED);
        map_region = rgn_q;
        map_bank   = bank_q;
        map_offset = off_q;
        map_wr     = map_valid & wr_q;
        map_float  = map_valid & flt_q;
    end

endmodule

// File: rtl/bmm_checker.sv
`timescale 1ns/1ps
module bmm_checker #(
    parameter int ADDR_W   = 16,
    parameter int BANK_W   = 4,
    localparam int OFFSET_W = ADDR_W - 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cpu_req,
    input logic                cpu_we,
    input logic [ADDR_W-1:0]   cpu_addr,
    input logic                bank_sel_we,
    input logic [BANK_W-1:0]   bank_sel_data,
    input logic [BANK_W-1:0]   cur_bank,
    input logic                map_valid,
    input logic [1:0]          map_region,
    input logic [OFFSET_W-1:0] map_offset,
    input logic                map_wr,
    input logic                map_float
);

    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |=> map_valid);

    a_r2_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |=> map_offset == $past(cpu_addr[OFFSET_W-1:0]));

    a_r8_idle_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |=> (!map_valid && !map_wr));

    a_r3_ram_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_addr[ADDR_W-1]) |=> map_wr == $past(cpu_we));

    a_r4_rom_never_written: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_addr[ADDR_W-1 -: 2] == 2'd3) |=> !map_wr);

    a_r6_bank_loads: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel_we |=> cur_bank == $past(bank_sel_data));

    a_r6_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_sel_we |=> $stable(cur_bank));

    a_r7_float_only_side_read: assert property (@(posedge clk) disable iff (!rst_n)
        map_float |-> (map_valid && map_region == 2'd1 && !map_wr));

endmodule

bind banked_mem_mapper bmm_checker #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
) u_bmm_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req       (cpu_req),
    .cpu_we        (cpu_we),
    .cpu_addr      (cpu_addr),
    .bank_sel_we   (bank_sel_we),
    .bank_sel_data (bank_sel_data),
    .cur_bank      (cur_bank),
    .map_valid     (map_valid),
    .map_region    (map_region),
    .map_offset    (map_offset),
    .map_wr        (map_wr),
    .map_float     (map_float)
);

// File: tb/tb_banked_mem_mapper.sv
`timescale 1ns/1ps
module tb_banked_mem_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        bank_sel_we = 1'b0;
    logic [3:0]  bank_sel_data = '0;
    logic [15:0] cfg_bank_writable = 16'h0025;  // banks 0, 2, 5 writable
    logic [15:0] cfg_bank_inserted = 16'h800D;  // banks 0, 2, 3, 15 populated
    logic        map_valid;
    logic [1:0]  map_region;
    logic [3:0]  map_bank;
    logic [13:0] map_offset;
    logic        map_wr;
    logic        map_float;

    banked_mem_mapper dut (
        .clk (clk), .rst_n (rst_n), .cpu_req (cpu_req), .cpu_we (cpu_we),
        .cpu_addr (cpu_addr), .bank_sel_we (bank_sel_we), .bank_sel_data (bank_sel_data),
        .cfg_bank_writable (cfg_bank_writable), .cfg_bank_inserted (cfg_bank_inserted),
        .map_valid (map_valid), .map_region (map_region), .map_bank (map_bank),
        .map_offset (map_offset), .map_wr (map_wr), .map_float (map_float)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        bit          valid;
        logic [1:0]  rgn;
        logic [3:0]  bank;
        logic [13:0] off;
        bit          wr;
        bit          flt;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    // Bench-side reference state, built from the requirements.
    logic [3:0] m_bank = 4'd15;
    bit         m_ins = 1'b1;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic cyc(input bit req, input bit we, input logic [15:0] a,
                       input bit swe, input logic [3:0] sd, input string tag);
        exp_t e;
        @(negedge clk);
        cpu_req = req; cpu_we = we; cpu_addr = a;
        bank_sel_we = swe; bank_sel_data = sd;
        e.valid = req;
        e.off   = a[13:0];
        e.tag   = tag;
        e.flt   = 1'b0;
        case (a[15:14])
            2'd0, 2'd1: begin e.rgn = 2'd0; e.bank = {3'b0, a[14]}; e.wr = req && we; end
            2'd2: begin
                e.rgn = 2'd1; e.bank = m_bank;
                e.wr  = req && we && cfg_bank_writable[m_bank];
                e.flt = req && !we && !m_ins;
            end
            default: begin e.rgn = 2'd2; e.bank = 4'd0; e.wr = 1'b0; end
        endcase
        exp_q.push_back(e);
        if (swe) begin
            m_bank = sd;
            m_ins  = cfg_bank_inserted[sd];
        end
    endtask

    // Monitor: compare each presented result one ns after the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, "valid", int'(map_valid), int'(e.valid));
            check(e.tag, "wr", int'(map_wr), int'(e.wr));
            if (e.valid) begin
                check(e.tag, "region", int'(map_region), int'(e.rgn));
                check(e.tag, "bank", int'(map_bank), int'(e.bank));
                check(e.tag, "offset", int'(map_offset), int'(e.off));
                check(e.tag, "float", int'(map_float), int'(e.flt));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1", "valid in reset", int'(map_valid), 0);
        check("R1", "wr in reset", int'(map_wr), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", "valid after reset", int'(map_valid), 0);
        check("R1", "wr after reset", int'(map_wr), 0);

        cyc(1, 0, 16'h8123, 0, 0, "R1 reset bank 15 read");
        cyc(1, 1, 16'h8456, 0, 0, "R5 bank 15 not writable");
        cyc(1, 1, 16'h0042, 0, 0, "R3 RAM low write");
        cyc(1, 1, 16'h4FFF, 0, 0, "R3 RAM high write");
        cyc(1, 0, 16'h7FFF, 0, 0, "R3 RAM high read");
        cyc(1, 1, 16'hC000, 0, 0, "R4 ROM write blocked");
        cyc(1, 0, 16'hFFFF, 0, 0, "R4 ROM read R2 offset");
        cyc(0, 1, 16'h0010, 0, 0, "R8 idle gap");
        cyc(1, 1, 16'h8000, 1, 4'd2, "R6 same-edge select uses old bank");
        cyc(1, 1, 16'hBFFF, 0, 0, "R6 next access uses bank 2");
        cyc(0, 0, 16'h0000, 1, 4'd5, "R8 select without request");
        cyc(1, 0, 16'h8001, 0, 0, "R7 empty bank read floats");
        cyc(1, 1, 16'h8001, 0, 0, "R7 empty bank write no float");
        @(negedge clk);
        cfg_bank_inserted[5] = 1'b1;
        exp_q.push_back('{valid: 0, rgn: 0, bank: 0, off: 0, wr: 0, flt: 0, tag: "R8 quiet"});
        cpu_req = 0; bank_sel_we = 0;
        cyc(1, 0, 16'h8002, 0, 0, "R7 stale flag still floats");
        cyc(0, 0, 16'h0000, 1, 4'd5, "R7 reselect bank 5");
        cyc(1, 0, 16'h8003, 0, 0, "R7 reselected bank no float");
        cyc(1, 1, 16'h9ABC, 1, 4'd3, "R5 bank 5 writable");
        cyc(1, 1, 16'h8ABC, 0, 0, "R5 bank 3 write blocked");
        cyc(1, 0, 16'hA5A5, 0, 0, "R2 bank 3 read offset");
        cyc(0, 0, 16'h0000, 0, 0, "R8 final idle");
        cyc(0, 0, 16'h0000, 0, 0, "R8 final idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule